// File: doc/BRIEF.md
# Threshold-Qualified Event Counter

This block is one counter of a performance-monitoring unit. Each clock cycle it receives the number of events that occurred in that cycle as a small unsigned count. A programmable comparison decides whether that cycle qualifies. The comparison checks the per-cycle count against a stored threshold. A qualifying cycle adds either its whole event count or a single unit to a wide accumulator. The unit added depends on a mode flag.

A threshold of zero switches the qualification off, and the counter then accumulates the raw event counts. The threshold, comparison code and mode flag are loaded through a one-cycle write strobe. A threshold above the supported maximum is clamped to that maximum. The maximum is published on a constant capability output. A build parameter can remove the threshold function altogether. In that build the capability reads zero and every configuration is ignored.

The accumulator wraps at its width and flags each wrap with a single-cycle pulse. The counter has an enable input and a synchronous clear.

Top module: `thr_event_counter`

## Requirements
- R1: After reset the accumulator reads 0, the wrap pulse is low and the stored threshold is 0, so raw counting is in force.
- R2: The comparison code selects how the per-cycle count C is tested against the threshold T: code 0 passes when C != T, code 1 when C == T, code 2 when C >= T, and code 3 when C < T.
- R3: With the mode flag clear and a nonzero threshold, a passing cycle adds C to the accumulator and a failing cycle adds nothing.
- R4: With the mode flag set and a nonzero threshold, a passing cycle adds exactly 1 whatever C is, and a failing cycle adds nothing.
- R5: While the stored threshold is 0, every enabled cycle adds C, whatever the comparison code and mode flag hold.
- R6: A written threshold above THR_MAX is stored as THR_MAX, and the capability output reads THR_MAX (default 255).
- R7: A configuration write takes effect for the cycle after the strobe. The cycle carrying the strobe is still qualified with the previous settings.
- R8: Clear sets the accumulator to 0 at the next edge and takes priority over enable. It leaves the configuration unchanged.
- R9: While enable is low and clear is low, the accumulator holds its value whatever the event input carries.
- R10: When an addition carries out of the ACC_W-bit accumulator, the accumulator keeps the low ACC_W bits and the wrap pulse is high for exactly that one cycle.
- R11: When built with THR_IMPL = 0, the capability output reads 0 and the counter always adds the raw count, ignoring all configuration writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_cnt | input | EVT_W (8) | Number of events seen in this cycle |
| cnt_en | input | 1 | Accumulate this cycle when high |
| clr | input | 1 | Synchronous clear of the accumulator |
| cfg_we | input | 1 | Load the three configuration fields at this edge |
| cfg_thr | input | 12 | Threshold value to load (clamped to THR_MAX) |
| cfg_cmp | input | 2 | Comparison code: 0 ne, 1 eq, 2 ge, 3 lt |
| cfg_one | input | 1 | Add 1 per passing cycle instead of the event count |
| acc | output | ACC_W (64) | Accumulator value |
| ovf | output | 1 | One-cycle pulse when the accumulator wraps |
| thr_cap | output | 12 | Largest supported threshold, 0 without the feature |

## Verification
The assertions assume that enable, clear and the event count are known values in every cycle after reset. They rely on these inputs being sampled only at the rising edge. They also assume that the event count never exceeds its EVT_W-bit range, which its width guarantees. The bench changes every input on the falling edge only and drives no X or Z after reset. It tests a second instance with a 10-bit accumulator and the feature removed. This lets the wrap pulse and the no-feature build be reached within a short run. The configuration values are written freely, including thresholds far above the maximum. The clamp is therefore exercised at the port rather than assumed.

// File: rtl/thr_pkg.sv
package thr_pkg;

    localparam int THR_W = 12;

    typedef enum logic [1:0] {
        CMP_NE = 2'd0,
        CMP_EQ = 2'd1,
        CMP_GE = 2'd2,
        CMP_LT = 2'd3
    } cmp_e;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        cmp_e             cmp;
        logic             one;
    } cfg_t;

endpackage

// File: rtl/thr_cfg_reg.sv
module thr_cfg_reg
    import thr_pkg::*;
#(
    parameter int THR_MAX  = 255,
    parameter bit THR_IMPL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [THR_W-1:0] thr_in,
    input  logic [1:0]       cmp_in,
    input  logic             one_in,
    output cfg_t             cfg
);

    localparam logic [THR_W-1:0] LIM = THR_W'(THR_MAX);

    cfg_t cfg_d, cfg_q;
    logic [THR_W-1:0] thr_lim;

    generate
        if (THR_IMPL) begin : g_impl
            assign thr_lim = (thr_in > LIM) ? LIM : thr_in;
        end else begin : g_none
            assign thr_lim = '0;
        end
    endgenerate

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.thr = thr_lim;
            cfg_d.cmp = cmp_e'(cmp_in);
            cfg_d.one = one_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{thr: '0, cmp: CMP_NE, one: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/thr_qualify.sv
module thr_qualify
    import thr_pkg::*;
#(
    parameter int EVT_W = 8
) (
    input  logic [EVT_W-1:0] evt,
    input  cfg_t             cfg,
    output logic [EVT_W-1:0] inc
);

    localparam int CW = (EVT_W > THR_W) ? EVT_W : THR_W;

    logic [CW-1:0] ev_x;
    logic [CW-1:0] th_x;
    logic          pass;

    assign ev_x = CW'(evt);
    assign th_x = CW'(cfg.thr);

    always_comb begin
        unique case (cfg.cmp)
            CMP_NE:  pass = (ev_x != th_x);
            CMP_EQ:  pass = (ev_x == th_x);
            CMP_GE:  pass = (ev_x >= th_x);
            default: pass = (ev_x <  th_x);
        endcase
        if (cfg.thr == '0) begin
            inc = evt;
        end else if (!pass) begin
            inc = '0;
        end else if (cfg.one) begin
            inc = EVT_W'(1);
        end else begin
            inc = evt;
        end
    end

endmodule

// File: rtl/thr_accum.sv
module thr_accum #(
    parameter int ACC_W = 64,
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [EVT_W-1:0] inc,
    output logic [ACC_W-1:0] acc,
    output logic             ovf
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovf;
    } st_t;

    st_t          st_d, st_q;
    logic [ACC_W:0] sum;

    assign sum = {1'b0, st_q.acc} + (ACC_W+1)'(inc);

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (clr) begin
            st_d.acc = '0;
        end else if (en) begin
            st_d.acc = sum[ACC_W-1:0];
            st_d.ovf = sum[ACC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;
    assign ovf = st_q.ovf;

endmodule

// File: rtl/thr_event_counter.sv
module thr_event_counter
    import thr_pkg::*;
#(
    parameter int EVT_W    = 8,
    parameter int ACC_W    = 64,
    parameter int THR_MAX  = 255,
    parameter bit THR_IMPL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_cnt,
    input  logic             cnt_en,
    input  logic             clr,
    input  logic             cfg_we,
    input  logic [11:0]      cfg_thr,
    input  logic [1:0]       cfg_cmp,
    input  logic             cfg_one,
    output logic [ACC_W-1:0] acc,
    output logic             ovf,
    output logic [11:0]      thr_cap
);

    localparam int THR_TOP = (1 << THR_W) - 1;
    localparam int CAP     = (THR_IMPL == 1'b0) ? 0 :
                             ((THR_MAX > THR_TOP) ? THR_TOP : THR_MAX);

    cfg_t             cfg_q;
    logic [EVT_W-1:0] inc;

    thr_cfg_reg #(
        .THR_MAX  (CAP),
        .THR_IMPL (THR_IMPL)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .thr_in (cfg_thr),
        .cmp_in (cfg_cmp),
        .one_in (cfg_one),
        .cfg    (cfg_q)
    );

    thr_qualify #(
        .EVT_W (EVT_W)
    ) u_qual (
        .evt (evt_cnt),
        .cfg (cfg_q),
        .inc (inc)
    );

    thr_accum #(
        .ACC_W (ACC_W),
        .EVT_W (EVT_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .clr   (clr),
        .inc   (inc),
        .acc   (acc),
        .ovf   (ovf)
    );

    assign thr_cap = 12'(CAP);

endmodule

// File: rtl/thr_event_counter_chk.sv
module thr_event_counter_chk #(
    parameter int ACC_W = 64,
    parameter int EVT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             clr,
    input logic [EVT_W-1:0] evt_cnt,
    input logic [ACC_W-1:0] acc,
    input logic             ovf,
    input logic [11:0]      thr_q,
    input logic             one_q
);

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0)); // R8

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !clr) |=> ($stable(acc) && !ovf)); // R9

    AST_RAW_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !clr && thr_q == '0) |=>
            (acc == ACC_W'($past(acc) + ACC_W'($past(evt_cnt))))); // R5

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !clr && thr_q != '0 && one_q) |=>
            (ACC_W'(acc - $past(acc)) <= ACC_W'(1))); // R4

    AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (acc < $past(acc))); // R10

endmodule

bind thr_event_counter thr_event_counter_chk #(
    .ACC_W (ACC_W),
    .EVT_W (EVT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .clr     (clr),
    .evt_cnt (evt_cnt),
    .acc     (acc),
    .ovf     (ovf),
    .thr_q   (cfg_q.thr),
    .one_q   (cfg_q.one)
);

// File: tb/thr_event_counter_bench.sv
module thr_event_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_cnt = '0;
    logic        cnt_en = 1'b0;
    logic        clr = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_thr = '0;
    logic [1:0]  cfg_cmp = '0;
    logic        cfg_one = 1'b0;

    logic [63:0] acc;
    logic        ovf;
    logic [11:0] thr_cap;
    logic [9:0]  acc_s;
    logic        ovf_s;
    logic [11:0] cap_s;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // reference state: main instance
    logic [63:0] m_acc = '0;
    logic        m_ovf = 1'b0;
    int          m_thr = 0;
    int          m_cmp = 0;
    bit          m_one = 1'b0;
    // reference state: small instance without the feature
    int          s_acc = 0;
    logic        s_ovf = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    thr_event_counter u_thr_event_counter (
        .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .cnt_en(cnt_en), .clr(clr),
        .cfg_we(cfg_we), .cfg_thr(cfg_thr), .cfg_cmp(cfg_cmp), .cfg_one(cfg_one),
        .acc(acc), .ovf(ovf), .thr_cap(thr_cap)
    );

    thr_event_counter #(.ACC_W(10), .THR_IMPL(1'b0)) u_small (
        .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .cnt_en(cnt_en), .clr(clr),
        .cfg_we(cfg_we), .cfg_thr(cfg_thr), .cfg_cmp(cfg_cmp), .cfg_one(cfg_one),
        .acc(acc_s), .ovf(ovf_s), .thr_cap(cap_s)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // model of one rising edge, using the inputs now on the pins
    task automatic model_edge();
        bit pass;
        int add;
        int ssum;
        case (m_cmp)
            0: pass = (evt_cnt != m_thr);
            1: pass = (evt_cnt == m_thr);
            2: pass = (evt_cnt >= m_thr);
            default: pass = (evt_cnt < m_thr);
        endcase
        if (m_thr == 0)      add = evt_cnt;
        else if (!pass)      add = 0;
        else if (m_one)      add = 1;
        else                 add = evt_cnt;
        m_ovf = 1'b0;
        s_ovf = 1'b0;
        if (clr) begin
            m_acc = '0;
            s_acc = 0;
        end else if (cnt_en) begin
            if (m_acc > 64'hFFFF_FFFF_FFFF_FFFF - 64'(add)) m_ovf = 1'b1;
            m_acc = m_acc + 64'(add);
            ssum  = s_acc + int'(evt_cnt);
            s_ovf = (ssum >= 1024);
            s_acc = ssum % 1024;
        end
        if (cfg_we) begin
            m_thr = (cfg_thr > 255) ? 255 : int'(cfg_thr);
            m_cmp = int'(cfg_cmp);
            m_one = cfg_one;
        end
    endtask

    task automatic step(input string tag, input int ev, input bit en, input bit cl,
                        input bit we, input int thr, input int cmp, input bit one);
        evt_cnt = 8'(ev);
        cnt_en  = en;
        clr     = cl;
        cfg_we  = we;
        cfg_thr = 12'(thr);
        cfg_cmp = 2'(cmp);
        cfg_one = one;
        model_edge();
        @(negedge clk);
        chk(tag, "acc", acc, m_acc);
        chk(tag, "ovf", 64'(ovf), 64'(m_ovf));
        chk(tag, "acc_small", 64'(acc_s), 64'(s_acc));
        chk(tag, "ovf_small", 64'(ovf_s), 64'(s_ovf));
    endtask

    task automatic cfg(input string tag, input int thr, input int cmp, input bit one);
        step(tag, 0, 1'b0, 1'b0, 1'b1, thr, cmp, one);
    endtask

    task automatic run(input string tag, input int ev);
        step(tag, ev, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "acc", acc, 64'd0);
        chk("R1", "ovf", 64'(ovf), 64'd0);
        // R6 / R11 capability values
        chk("R6", "thr_cap", 64'(thr_cap), 64'd255);
        chk("R11", "thr_cap_small", 64'(cap_s), 64'd0);

        // R1: threshold 0 after reset means raw counts
        run("R1", 6);
        // R5: threshold 0 with eq/one configured still counts raw
        cfg("R5", 0, 1, 1'b1);
        run("R5", 17);
        run("R5", 0);
        run("R5", 200);
        // R9: enable low holds
        step("R9", 99, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
        step("R9", 255, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
        // R7: write in same cycle as an event: old (raw) config applies
        step("R7", 7, 1'b1, 1'b0, 1'b1, 2, 2, 1'b0);
        // R3: ge 2, full count
        run("R3", 3);
        run("R3", 1);
        run("R3", 2);
        // R2: eq 4
        cfg("R2", 4, 1, 1'b0);
        run("R2", 4);
        run("R2", 5);
        // R2: ne 4
        cfg("R2", 4, 0, 1'b0);
        run("R2", 4);
        run("R2", 6);
        // R2: lt 4
        cfg("R2", 4, 3, 1'b0);
        run("R2", 3);
        run("R2", 4);
        run("R2", 0);
        // R4: lt 10, add one
        cfg("R4", 10, 3, 1'b1);
        run("R4", 0);
        run("R4", 9);
        run("R4", 10);
        cfg("R4", 2, 2, 1'b1);
        run("R4", 200);
        run("R4", 1);
        // R6: clamp 4000 -> 255 under ge
        cfg("R6", 4000, 2, 1'b0);
        run("R6", 255);
        run("R6", 254);
        // R8: clear beats enable, config retained
        step("R8", 255, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0);
        run("R8", 255);
        run("R8", 100);
        // R10 / R11: small instance wraps; its config is ignored
        step("R10", 0, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0);
        for (int i = 0; i < 4; i++) run("R11", 255);
        run("R10", 10);
        run("R10", 0);
        run("R10", 3);
        for (int i = 0; i < 12; i++) run("R10", 250 - i);
        finish_run();
    end

endmodule